// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block collects single-cycle event pulses from five peripheral sources into sticky flags and turns them into one active-high interrupt request. The sources are the timer A underflow, the timer B underflow, the time-of-day alarm, the serial-shift completion and an external flag pin. An enable mask chooses which flags may raise the request.

The host reaches the block through one register slot, selected by `sel_i`. A write to the slot (`we_i` = 1) changes the enable mask. Data bit 7 says whether the write sets or clears enable bits. Data bits 4:0 say which enable bits the write touches, and the other enable bits keep their values.

A read from the slot (`we_i` = 0) returns the flags together with the summary request bit, and empties the register at the next clock edge. The request is sticky. Once it is raised, only a read or a reset brings it down.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Event input bit n latches into read-data bit n. Bit 0 is timer A, bit 1 is timer B, bit 2 is the alarm, bit 3 is the serial port and bit 4 is the external pin. Read-data bits 6:5 always read 0, and read-data bit 7 is the summary request, equal to `irq_o`.
- R2: A write whose data bit 7 is 1 sets every enable bit whose data bit in 4:0 is 1. All other enable bits keep their values.
- R3: A write whose data bit 7 is 0 clears every enable bit whose data bit in 4:0 is 1. All other enable bits keep their values.
- R4: A write that enables a flag which is already latched raises `irq_o` at the clock edge that ends the write cycle.
- R5: When a latched flag has its enable bit set, `irq_o` and read-data bit 7 are 1 from the edge that latched it. A flag whose enable bit is clear still latches but does not raise `irq_o`.
- R6: Once `irq_o` is 1, it stays 1 until a read or a reset. Further events do not lower it, and neither do mask writes that disable every source.
- R7: A read presents the current flag register on `rdata_o` in the same cycle. At the edge that ends the read, every flag clears and `irq_o` falls.
- R8: An event that arrives in the same cycle as a read is not lost. It is the only content of the flags after that read, and it raises `irq_o` again if its enable bit is set.
- R9: While `rst_n` is low at a clock edge, the mask, the flags and `irq_o` all clear.
- R10: A flag stays latched across any number of idle cycles and across mask writes until it is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Strobe for the interrupt register slot, one cycle per access |
| we_i | input | 1 | Access direction while selected: 1 writes the mask, 0 reads the flags |
| wdata_i | input | 8 | Write data: bit 7 selects set or clear, bits 4:0 select enable bits |
| evt_i | input | 5 | Single-cycle event pulses, one bit per source |
| rdata_o | output | 8 | Flag register: bits 4:0 are the flags, bit 7 is the summary, bits 6:5 are 0 |
| irq_o | output | 1 | Registered active-high interrupt request |

## Verification
The bench first pulses each source alone with the mask empty, so a wrong bit position shows up in the read value while `irq_o` stays low. It then uses set writes and clear writes that each touch one enable bit while other enable bits are held, which separates a correct read-modify-write from a whole-mask overwrite. Further sequences enable a flag after it has already latched and disable the mask while a request is pending, which tells a sticky request from a plain level compare. Reads with a coincident event, both enabled and masked, show whether the event survives the clear.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the interrupt flag controller.
// Assumes: every event source owns one flag bit, and the sources are
// numbered from bit 0 upward.
package irqc_pkg;

    // Number of event sources handled by the controller.
    localparam int unsigned SRC_COUNT = 5;

    // Bit position of each source inside the flag and mask registers.
    typedef enum int unsigned {
        SRC_TMR_A  = 0,
        SRC_TMR_B  = 1,
        SRC_ALARM  = 2,
        SRC_SERIAL = 3,
        SRC_EXT    = 4
    } src_idx_e;

endpackage

// File: rtl/irqc_mask_reg.sv
// Module: enable-mask register with set/clear write semantics.
// Does: on a write, set_i = 1 ORs bits_i into the mask, and set_i = 0
// removes bits_i from it. Bits that are 0 in bits_i are left alone.
// Assumes: wr_i lasts one cycle per access. mask_next_o is the value the
// mask takes at the coming edge, for use by the request logic.
module irqc_mask_reg #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            set_i,
    input  logic [NSRC-1:0] bits_i,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] mask_next_o
);

    logic [NSRC-1:0] mask_q;

    // Next mask value after a set write, a clear write, or no write.
    always_comb begin
        mask_next_o = mask_q;
        if (wr_i) begin
            if (set_i) mask_next_o = mask_q | bits_i;
            else       mask_next_o = mask_q & ~bits_i;
        end
    end

    // Mask storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_next_o;
    end

    assign mask_o = mask_q;

    // A set write leaves every selected bit at 1.
    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && set_i) |=> ((mask_o & $past(bits_i)) == $past(bits_i)));

    // A clear write leaves every selected bit at 0.
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !set_i) |=> ((mask_o & $past(bits_i)) == '0));

    // Without a write the mask holds its value.
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

endmodule

// File: rtl/irqc_flag_bank.sv
// Module: bank of sticky event flags with a clear-on-read.
// Does: each flag is set by its event pulse and stays set until a read.
// A read clears the bank at the edge that ends it, but an event pulse in
// that same cycle still sets its flag.
// Assumes: events are single-cycle pulses, and rd_i lasts one cycle.
module irqc_flag_bank #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_i,
    input  logic [NSRC-1:0] evt_i,
    output logic [NSRC-1:0] flags_o,
    output logic [NSRC-1:0] flags_next_o
);

    logic [NSRC-1:0] flag_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        // Next value of one flag: the event wins over the read clear.
        assign flags_next_o[i] = evt_i[i] | (flag_q[i] & ~rd_i);

        // One sticky flag bit with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= flags_next_o[i];
        end
    end

    assign flags_o = flag_q;

    // Latched flags survive every cycle without a read.
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // After a read only the events of the read cycle remain.
    p_read_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (flags_o == $past(evt_i)));

    // A read with no coincident event empties the bank.
    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && evt_i == '0) |=> (flags_o == '0));

endmodule

// File: rtl/irqc_req_gen.sv
// Module: registered interrupt request generator.
// Does: raises the request when any next-state flag meets its next-state
// enable bit. The request is sticky until a read. A read restarts the
// request from the events that arrive in the read cycle.
// Assumes: flags_next_i and mask_next_i are the values the flag bank and
// the mask take at the coming edge.
module irqc_req_gen #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_i,
    input  logic [NSRC-1:0] flags_next_i,
    input  logic [NSRC-1:0] mask_next_i,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] mask_i,
    output logic            req_o
);

    logic req_q;
    logic hit_next;

    // Any enabled flag pending after the coming edge.
    assign hit_next = |(flags_next_i & mask_next_i);

    // Sticky request: a read drops it unless an enabled event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)    req_q <= 1'b0;
        else if (rd_i) req_q <= hit_next;
        else           req_q <= req_q | hit_next;
    end

    assign req_o = req_q;

    // An enabled pending flag always shows as an active request.
    p_req_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_i & mask_i)) |-> req_o);

    // An active request is held until a read (R6).
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !rd_i) |=> req_o);

    // Reset leaves the request low.
    p_req_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !req_o);

endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: top of the maskable interrupt flag controller.
// Does: decodes the single register slot into a mask write or a flag read,
// and joins the flag bank, the mask and the request generator. Read data
// shows the flags in the low bits and the request in the top bit.
// Assumes: sel_i is a one-cycle strobe per access. Write data bit DATA_W-1
// picks set (1) or clear (0) for the mask.
module evt_irq_ctrl #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NSRC   = irqc_pkg::SRC_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSRC-1:0]   evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int unsigned SUM_POS = DATA_W - 1;

    logic            wr_stb;
    logic            rd_stb;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] mask_nx;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] flag_nx;
    logic            req_q;

    // Split the slot strobe into write and read accesses.
    assign wr_stb = sel_i & we_i;
    assign rd_stb = sel_i & ~we_i;

    irqc_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_stb),
        .set_i       (wdata_i[SUM_POS]),
        .bits_i      (wdata_i[NSRC-1:0]),
        .mask_o      (mask_q),
        .mask_next_o (mask_nx)
    );

    irqc_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_i         (rd_stb),
        .evt_i        (evt_i),
        .flags_o      (flag_q),
        .flags_next_o (flag_nx)
    );

    irqc_req_gen #(.NSRC(NSRC)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_i         (rd_stb),
        .flags_next_i (flag_nx),
        .mask_next_i  (mask_nx),
        .flags_i      (flag_q),
        .mask_i       (mask_q),
        .req_o        (req_q)
    );

    // Build the read word: flags low, summary high, unused bits zero.
    always_comb begin
        rdata_o              = '0;
        rdata_o[NSRC-1:0]    = flag_q;
        rdata_o[SUM_POS]     = req_q;
    end

    assign irq_o = req_q;

    // An enabled flag latched by an event shows as a request on the port.
    p_evt_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & mask_nx)) |=> irq_o);

endmodule

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, and a monitor pops
// them and compares them against rdata_o during each read cycle.
module sim_evt_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [4:0] evt = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    evt_irq_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .we_i    (we),
        .wdata_i (wdata),
        .evt_i   (evt),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // Drive one cycle of inputs, just after a rising edge.
    task automatic drive(input bit s, input bit w, input logic [7:0] d, input logic [4:0] e);
        @(posedge clk); #1;
        sel = s; we = w; wdata = d; evt = e;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 8'h00, 5'h00);
    endtask

    task automatic pulse(input logic [4:0] e);
        drive(1'b0, 1'b0, 8'h00, e);
        idle();
    endtask

    task automatic wr_mask(input logic [7:0] d);
        drive(1'b1, 1'b1, d, 5'h00);
        idle();
    endtask

    // Issue a read and queue its expected word.
    task automatic rd_exp(input logic [7:0] exp, input string tag, input logic [4:0] e = 5'h00);
        drive(1'b1, 1'b0, 8'h00, e);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        idle();
    endtask

    // Compare irq_o at the next falling edge.
    task automatic chk_irq(input bit exp, input string tag);
        @(negedge clk);
        n_cmp++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_o actual %0b expected %0b", tag, irq, exp);
        end
    endtask

    // Monitor: pop and compare during every read cycle.
    always @(negedge clk) begin
        if (rst_n && sel && !we) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none", rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata_o actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9: state after reset
        chk_irq(1'b0, "R9 reset irq");
        rd_exp(8'h00, "R9 reset flags");

        // R1 and R5: each source alone, mask empty
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i));
            chk_irq(1'b0, "R5 masked flag no irq");
            rd_exp(8'(1 << i), "R1 bit position");
        end
        pulse(5'h1f);
        rd_exp(8'h1f, "R1 all sources");

        // R2 and R5: enable timer A
        wr_mask(8'h81);
        pulse(5'h01);
        chk_irq(1'b1, "R5 enabled flag raises irq");
        rd_exp(8'h81, "R5 summary bit");
        chk_irq(1'b0, "R7 read drops irq");
        rd_exp(8'h00, "R7 flags cleared");

        // R3: disable timer A
        wr_mask(8'h01);
        pulse(5'h01);
        chk_irq(1'b0, "R3 cleared enable");
        rd_exp(8'h01, "R3 flag still latches");

        // R2 and R3: other bits kept
        wr_mask(8'h82);
        wr_mask(8'h84);
        pulse(5'h02);
        chk_irq(1'b1, "R2 earlier set bit kept");
        rd_exp(8'h82, "R2 read");
        wr_mask(8'h02);
        pulse(5'h04);
        chk_irq(1'b1, "R3 other bit kept");
        rd_exp(8'h84, "R3 read");

        // R4: enable an already latched flag
        wr_mask(8'h04);
        pulse(5'h08);
        chk_irq(1'b0, "R4 before enable");
        drive(1'b1, 1'b1, 8'h88, 5'h00);
        idle();
        chk_irq(1'b1, "R4 after enable");
        rd_exp(8'h88, "R4 read");

        // R6: request held through mask clear and further events
        pulse(5'h08);
        chk_irq(1'b1, "R6 raised");
        wr_mask(8'h08);
        chk_irq(1'b1, "R6 hold after mask clear");
        pulse(5'h01);
        chk_irq(1'b1, "R6 hold after event");
        rd_exp(8'h89, "R6 read");
        chk_irq(1'b0, "R7 dropped");

        // R10: sticky over idle cycles and mask writes
        pulse(5'h10);
        repeat (20) idle();
        rd_exp(8'h10, "R10 idle hold");
        pulse(5'h02);
        wr_mask(8'h9d);
        chk_irq(1'b0, "R10 unenabled flag");
        rd_exp(8'h02, "R10 kept across write");

        // R8: event coincident with read
        pulse(5'h01);
        rd_exp(8'h81, "R8 read before", 5'h08);
        chk_irq(1'b1, "R8 kept event requests");
        rd_exp(8'h88, "R8 kept event");
        chk_irq(1'b0, "R8 cleared");
        wr_mask(8'h1f);
        pulse(5'h04);
        rd_exp(8'h04, "R8 masked read", 5'h02);
        chk_irq(1'b0, "R8 masked no irq");
        rd_exp(8'h02, "R8 masked kept");

        // R9: reset mid-run
        wr_mask(8'h9f);
        pulse(5'h1f);
        chk_irq(1'b1, "R9 before reset");
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_irq(1'b0, "R9 irq cleared");
        rd_exp(8'h00, "R9 flags cleared");
        pulse(5'h01);
        chk_irq(1'b0, "R9 mask cleared");
        rd_exp(8'h01, "R9 flag after reset");

        repeat (3) idle();
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule